// File: doc/BRIEF.md
# Single-to-Double Float Load Converter

This combinational block widens a 32-bit IEEE-754 single-precision word into a 64-bit double-precision word, the way a floating-point register file does when a short real is loaded from memory. With the result it returns a class tag in two levels. The main tag says whether the register holds zero, an ordinary valid number or something special. The sub-tag tells the special cases apart: indefinite, infinity, quiet NaN, signalling NaN or denormal.

Finite inputs are converted exactly. Single-precision subnormals are renormalized into ordinary doubles. For these inputs the tag is read from the widened result and not from the input fields. Special inputs (exponent all ones) go through a NaN translation path. This path is controlled by a convention input. In the standard convention a set top mantissa bit means quiet. In the inverted convention that bit means signalling, and the default NaN has a different bit pattern. The NaN class is always taken from the input word before any translation, so the sub-tag names the class in the standard convention.

Top module: `fpld_s2d_load`

## Requirements
- R1: An input whose 8-bit exponent field (bits 30:23) is all ones gets main tag special (main tag encoding: 0 zero, 1 valid, 2 special).
- R2: Input 0xFFC00000 is the default NaN and gets sub-tag 1. With `nan_inv`=0 the output is 0xFFF8000000000000. With `nan_inv`=1 the output is 0x7FF7FFFFFFFFFFFF.
- R3: Input 0x7F800000 gives 0x7FF0000000000000 and input 0xFF800000 gives 0xFFF0000000000000, in either convention. Both get sub-tag 2.
- R4: Any other special input with a nonzero mantissa gets sub-tag 3 when input bit 22 is 1 and sub-tag 4 when it is 0, in either convention.
- R5: Such a NaN becomes {sign, eleven ones, m', 29 zeros}. Here m' is the 23-bit input mantissa, with bit 22 inverted when `nan_inv`=1.
- R6: A normal single (exponent 1..254) becomes {sign, exponent+896, mantissa, 29 zeros}, with main tag 1 and sub-tag 0 (sub-tag encoding: 0 none, 1 default NaN, 2 infinity, 3 quiet, 4 signalling, 5 denormal).
- R7: A single subnormal (exponent 0, nonzero mantissa) with k leading zeros in its 23-bit mantissa becomes a normal double. Its exponent is 896-k, and its fraction is the mantissa shifted left by k+1 with the leading one dropped, followed by 29 zeros. It gets main tag 1 and sub-tag 0.
- R8: +0 and -0 become 64-bit zeros with the same sign bit, with main tag 0 and sub-tag 0.
- R9: `nan_inv` has no effect on the output word or the tags of finite inputs or infinities.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| flt_in | input | 32 | Single-precision word to load |
| nan_inv | input | 1 | 0: standard NaN convention; 1: inverted quiet bit and alternate default NaN |
| dbl_out | output | 64 | Widened double-precision word |
| main_tag | output | 2 | 0 zero, 1 valid, 2 special |
| sub_tag | output | 3 | 0 none, 1 default NaN, 2 infinity, 3 quiet NaN, 4 signalling NaN, 5 denormal |

## Verification
The assertions assume only that `flt_in` and `nan_inv` are stable two-state values. They check the output encoding against the tag: where the exponent sits, whether the infinity mantissa is clean, and whether the sign is preserved. The random stimulus draws exponent classes on purpose (zero, all ones and normal), so that subnormals and NaNs appear often and are not left to chance. Directed vectors cover the default NaN, the single-bit NaN payloads that turn into infinity-shaped words under inversion, the smallest and largest subnormals, and both zeros. Each vector is applied under both conventions where R9 applies.

// File: rtl/fpld_pkg.sv
// Shared tag types for the single-to-double load converter.
package fpld_pkg;

    // Main register class tag.
    typedef enum logic [1:0] {
        MT_ZERO    = 2'd0,
        MT_VALID   = 2'd1,
        MT_SPECIAL = 2'd2
    } main_tag_e;

    // Detail tag for special registers.
    typedef enum logic [2:0] {
        ST_NONE   = 3'd0,
        ST_INDEF  = 3'd1,
        ST_INF    = 3'd2,
        ST_QNAN   = 3'd3,
        ST_SNAN   = 3'd4,
        ST_DENORM = 3'd5
    } sub_tag_e;

    // Field decode of the incoming narrow word.
    typedef struct packed {
        logic exp_ones;
        logic exp_zero;
        logic man_zero;
        logic quiet;
        logic indef;
    } in_class_t;

endpackage

// File: rtl/fpld_lzc.sv
// Leading-zero counter.
// Counts the zeros above the most significant set bit of vec.
// Assumes: an all-zero vec returns W; callers that use the count
// ignore that case.
module fpld_lzc #(
    parameter int W  = 23,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);

    // Priority scan from the top bit down.
    always_comb begin
        logic found;
        found = 1'b0;
        cnt   = CW'(W);
        for (int i = W - 1; i >= 0; i--) begin
            if (!found && vec[i]) begin
                cnt   = CW'(W - 1 - i);
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpld_classify.sv
// Field decoder for the narrow input word.
// Flags an all-ones or all-zero exponent, a zero mantissa, the top
// mantissa bit, and an exact match with the default NaN pattern.
// Assumes: the word layout is {sign, exponent, mantissa}.
module fpld_classify #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0]  word,
    output fpld_pkg::in_class_t   cls
);

    localparam int W = EXP_W + MAN_W + 1;
    localparam logic [W-1:0] INDEF_PAT =
        {1'b1, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    assign exp_f = word[W-2 -: EXP_W];
    assign man_f = word[MAN_W-1:0];

    // Decode the class flags from the fields.
    always_comb begin
        cls.exp_ones = &exp_f;
        cls.exp_zero = ~|exp_f;
        cls.man_zero = ~|man_f;
        cls.quiet    = man_f[MAN_W-1];
        cls.indef    = (word == INDEF_PAT);
    end

endmodule

// File: rtl/fpld_widen_finite.sv
// Exact widening of finite values (normal, subnormal, zero).
// A normal value is rebiased. A subnormal is renormalized: its
// leading one becomes the hidden bit and the exponent drops by the
// leading-zero count. A zero keeps its sign.
// Assumes: exponent is not all ones; that path is handled elsewhere.
module fpld_widen_finite #(
    parameter int SE = 8,
    parameter int SM = 23,
    parameter int DE = 11,
    parameter int DM = 52
) (
    input  logic           sign,
    input  logic [SE-1:0]  exp_in,
    input  logic [SM-1:0]  man_in,
    output logic [DE+DM:0] word
);

    localparam int SP_BIAS   = (1 << (SE - 1)) - 1;
    localparam int DP_BIAS   = (1 << (DE - 1)) - 1;
    localparam int BIAS_DIFF = DP_BIAS - SP_BIAS;
    localparam int LZ_W      = $clog2(SM + 1);
    localparam int PAD       = DM - SM;

    logic [LZ_W-1:0] lz;
    logic [DE-1:0]   exp_w;
    logic [SM-1:0]   frac_w;

    fpld_lzc #(.W(SM), .CW(LZ_W)) u_lzc (
        .vec (man_in),
        .cnt (lz)
    );

    // Pick the rebased exponent and the aligned fraction.
    always_comb begin
        exp_w  = DE'(exp_in) + DE'(BIAS_DIFF);
        frac_w = man_in;
        if (exp_in == '0) begin
            if (man_in == '0) begin
                exp_w  = '0;
                frac_w = '0;
            end else begin
                exp_w  = DE'(BIAS_DIFF) - DE'(lz);
                frac_w = (man_in << lz) << 1;
            end
        end
    end

    // Assemble the wide word.
    always_comb word = {sign, exp_w, frac_w, {PAD{1'b0}}};

endmodule

// File: rtl/fpld_nan_map.sv
// Translation of special inputs (exponent all ones) to the wide format.
// The default NaN goes to the pattern of the selected convention.
// Infinities keep their sign. Any other NaN payload is left-aligned,
// with its top bit inverted under the inverted convention.
// Assumes: it is used only when the input exponent is all ones.
module fpld_nan_map #(
    parameter int SM = 23,
    parameter int DE = 11,
    parameter int DM = 52
) (
    input  logic           sign,
    input  logic [SM-1:0]  man_in,
    input  logic           is_indef,
    input  logic           man_zero,
    input  logic           nan_inv,
    output logic [DE+DM:0] word
);

    localparam int PAD = DM - SM;
    localparam logic [DE+DM:0] INDEF_STD =
        {1'b1, {DE{1'b1}}, 1'b1, {(DM-1){1'b0}}};
    localparam logic [DE+DM:0] INDEF_INV =
        {1'b0, {DE{1'b1}}, 1'b0, {(DM-1){1'b1}}};
    localparam logic [SM-1:0] QBIT = SM'(1) << (SM - 1);

    logic [SM-1:0] payload;

    // Flip the quiet bit under the inverted convention.
    always_comb payload = nan_inv ? (man_in ^ QBIT) : man_in;

    // Choose default NaN, infinity or translated payload.
    always_comb begin
        if (is_indef)
            word = nan_inv ? INDEF_INV : INDEF_STD;
        else if (man_zero)
            word = {sign, {DE{1'b1}}, {DM{1'b0}}};
        else
            word = {sign, {DE{1'b1}}, payload, {PAD{1'b0}}};
    end

endmodule

// File: rtl/fpld_s2d_load.sv
// Single-to-double load converter (top, combinational).
// Widens a narrow float into the wide format and tags the result.
// Special inputs are tagged from the input fields. Finite inputs are
// tagged from the widened word.
// Assumes: two-state inputs that stay stable while the output is used.
module fpld_s2d_load #(
    parameter int SP_EXP_W = 8,
    parameter int SP_MAN_W = 23,
    parameter int DP_EXP_W = 11,
    parameter int DP_MAN_W = 52
) (
    input  logic [SP_EXP_W+SP_MAN_W:0] flt_in,
    input  logic                       nan_inv,
    output logic [DP_EXP_W+DP_MAN_W:0] dbl_out,
    output logic [1:0]                 main_tag,
    output logic [2:0]                 sub_tag
);
    import fpld_pkg::*;

    localparam int SW = SP_EXP_W + SP_MAN_W + 1;
    localparam int DW = DP_EXP_W + DP_MAN_W + 1;

    in_class_t       cls;
    logic [DW-1:0]   fin_word;
    logic [DW-1:0]   nan_word;
    logic [DP_EXP_W-1:0] res_exp;
    logic [DP_MAN_W-1:0] res_man;
    logic            res_mag_zero;
    main_tag_e       mtag;
    sub_tag_e        stag;

    fpld_classify #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_cls (
        .word (flt_in),
        .cls  (cls)
    );

    fpld_widen_finite #(
        .SE(SP_EXP_W), .SM(SP_MAN_W), .DE(DP_EXP_W), .DM(DP_MAN_W)
    ) u_fin (
        .sign   (flt_in[SW-1]),
        .exp_in (flt_in[SW-2 -: SP_EXP_W]),
        .man_in (flt_in[SP_MAN_W-1:0]),
        .word   (fin_word)
    );

    fpld_nan_map #(.SM(SP_MAN_W), .DE(DP_EXP_W), .DM(DP_MAN_W)) u_nan (
        .sign     (flt_in[SW-1]),
        .man_in   (flt_in[SP_MAN_W-1:0]),
        .is_indef (cls.indef),
        .man_zero (cls.man_zero),
        .nan_inv  (nan_inv),
        .word     (nan_word)
    );

    // Route the special or the finite path to the output.
    always_comb dbl_out = cls.exp_ones ? nan_word : fin_word;

    // Split the widened result for tagging.
    always_comb begin
        res_exp      = dbl_out[DW-2 -: DP_EXP_W];
        res_man      = dbl_out[DP_MAN_W-1:0];
        res_mag_zero = (res_exp == '0) && (res_man == '0);
    end

    // Derive the two-level tag.
    always_comb begin
        if (cls.exp_ones) begin
            mtag = MT_SPECIAL;
            if (cls.indef)         stag = ST_INDEF;
            else if (cls.man_zero) stag = ST_INF;
            else if (cls.quiet)    stag = ST_QNAN;
            else                   stag = ST_SNAN;
        end else if (res_mag_zero) begin
            mtag = MT_ZERO;
            stag = ST_NONE;
        end else if (res_exp == '0) begin
            mtag = MT_SPECIAL;
            stag = ST_DENORM;
        end else begin
            mtag = MT_VALID;
            stag = ST_NONE;
        end
    end

    assign main_tag = mtag;
    assign sub_tag  = stag;

    // Output encoding checks against the tags.
    always_comb begin
        // R1: a special tag holds only an extreme wide exponent
        a_r1_special_main: assert (mtag != MT_SPECIAL ||
            res_exp == '1 || res_exp == '0)
            else $error("special tag with ordinary exponent");
        // R3: infinity carries no payload
        a_r3_inf_clean: assert (stag != ST_INF || res_man == '0)
            else $error("infinity with payload");
        // R5: NaN classes keep an all-ones exponent
        a_r5_nan_exp: assert (!(stag == ST_QNAN || stag == ST_SNAN) ||
            res_exp == '1)
            else $error("NaN lost exponent");
        // R6: valid numbers have an ordinary exponent
        a_r6_valid_exp: assert (mtag != MT_VALID ||
            (res_exp != '0 && res_exp != '1))
            else $error("valid tag with extreme exponent");
        // R8: sign preserved except for the default NaN remap
        a_r8_sign_kept: assert (stag == ST_INDEF ||
            dbl_out[DW-1] == flt_in[SW-1])
            else $error("sign changed");
        // R2: inverted default NaN is positive
        a_r2_indef_inv: assert (!(stag == ST_INDEF && nan_inv) ||
            !dbl_out[DW-1])
            else $error("inverted default NaN sign");
    end

endmodule

// File: tb/fpld_s2d_load_tb.sv
module fpld_s2d_load_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] flt_in = '0;
    logic        nan_inv = 1'b0;
    logic [63:0] dbl_out;
    logic [1:0]  main_tag;
    logic [2:0]  sub_tag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    fpld_s2d_load u_dut (
        .flt_in   (flt_in),
        .nan_inv  (nan_inv),
        .dbl_out  (dbl_out),
        .main_tag (main_tag),
        .sub_tag  (sub_tag)
    );

    // Reference widening, written from the requirements.
    function automatic logic [63:0] ref_word(input logic [31:0] w, input bit inv);
        logic [7:0]  e;
        logic [22:0] m;
        logic [23:0] mm;
        int          ex;
        e = w[30:23];
        m = w[22:0];
        if (e == 8'hFF) begin
            if (w == 32'hFFC00000)
                return inv ? 64'h7FF7FFFF_FFFFFFFF : 64'hFFF80000_00000000;
            if (m == 0) return {w[31], 11'h7FF, 52'd0};
            if (inv) m[22] = ~m[22];
            return {w[31], 11'h7FF, m, 29'd0};
        end
        if (e == 0) begin
            if (m == 0) return {w[31], 63'd0};
            mm = {1'b0, m};
            ex = -126;
            while (!mm[23]) begin
                mm = mm << 1;
                ex = ex - 1;
            end
            return {w[31], 11'(ex + 1023), mm[22:0], 29'd0};
        end
        return {w[31], 11'(int'(e) - 127 + 1023), m, 29'd0};
    endfunction

    function automatic logic [4:0] ref_tags(input logic [31:0] w);
        if (w[30:23] == 8'hFF) begin
            if (w == 32'hFFC00000)  return {2'd2, 3'd1};
            if (w[22:0] == 0)       return {2'd2, 3'd2};
            if (w[22])              return {2'd2, 3'd3};
            return {2'd2, 3'd4};
        end
        if (w[30:0] == 0) return {2'd0, 3'd0};
        return {2'd1, 3'd0};
    endfunction

    function automatic string req_of(input logic [31:0] w);
        if (w == 32'hFFC00000)     return "R2";
        if (w[30:23] == 8'hFF)     return (w[22:0] == 0) ? "R3" : "R4/R5/R1";
        if (w[30:0] == 0)          return "R8";
        if (w[30:23] == 0)         return "R7";
        return "R6";
    endfunction

    task automatic apply(input logic [31:0] w, input bit inv, input string req);
        logic [63:0] ew;
        logic [4:0]  et;
        @(posedge clk);
        flt_in  = w;
        nan_inv = inv;
        @(negedge clk);
        ew = ref_word(w, inv);
        et = ref_tags(w);
        n_checks++;
        if (dbl_out !== ew || {main_tag, sub_tag} !== et) begin
            n_fail++;
            $display("FAIL %s in=%h inv=%0d actual=%h/%0d/%0d expected=%h/%0d/%0d",
                     req, w, inv, dbl_out, main_tag, sub_tag, ew, et[4:3], et[2:0]);
        end
    endtask

    // R9: a finite or infinite input gives identical results in both modes.
    task automatic both_modes(input logic [31:0] w);
        logic [63:0] w0;
        logic [4:0]  t0;
        apply(w, 1'b0, req_of(w));
        w0 = dbl_out;
        t0 = {main_tag, sub_tag};
        apply(w, 1'b1, req_of(w));
        n_checks++;
        if (dbl_out !== w0 || {main_tag, sub_tag} !== t0) begin
            n_fail++;
            $display("FAIL R9 in=%h actual=%h/%h expected=%h/%h",
                     w, dbl_out, {main_tag, sub_tag}, w0, t0);
        end
    endtask

    initial begin : watchdog
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        int seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state: input zero reads as +0, tagged zero (R8)
        n_checks++;
        if (dbl_out !== 64'd0 || main_tag !== 2'd0 || sub_tag !== 3'd0) begin
            n_fail++;
            $display("FAIL R8 reset actual=%h/%0d/%0d expected=0/0/0",
                     dbl_out, main_tag, sub_tag);
        end

        // R8 signed zeros, R9 mode independence
        both_modes(32'h00000000);
        both_modes(32'h80000000);
        // R6 normals
        both_modes(32'h3F800000);
        both_modes(32'hC0490FDB);
        both_modes(32'h7F7FFFFF);
        both_modes(32'h00800000);
        // R7 subnormals at both ends
        both_modes(32'h00000001);
        both_modes(32'h807FFFFF);
        both_modes(32'h00400000);
        // R3 infinities
        both_modes(32'h7F800000);
        both_modes(32'hFF800000);
        // R2 default NaN in both conventions
        apply(32'hFFC00000, 1'b0, "R2");
        apply(32'hFFC00000, 1'b1, "R2");
        // R4/R5 quiet and signalling NaNs, including payloads that become
        // infinity-shaped under inversion
        apply(32'h7FC00000, 1'b0, "R4");
        apply(32'h7FC00000, 1'b1, "R5");
        apply(32'h7F800001, 1'b0, "R4");
        apply(32'h7F800001, 1'b1, "R5");
        apply(32'hFFC00001, 1'b1, "R4");
        apply(32'h7FFFFFFF, 1'b1, "R5");
        apply(32'hFFBFFFFF, 1'b0, "R1");

        // Constrained random mix across exponent classes.
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] w;
            int          k;
            w = $urandom;
            k = $urandom_range(0, 3);
            if (k == 0) w[30:23] = 8'h00;
            else if (k == 1) w[30:23] = 8'hFF;
            if (w[30:23] == 8'hFF || w[30:23] == 8'h00 || k == 3)
                apply(w, 1'($urandom_range(0, 1)), req_of(w));
            else
                both_modes(w);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule